// File: doc/BRIEF.md
# Serial Configuration Stream Frame Parser

This block takes a configuration bitstream one bit per clock, qualified by a valid strobe, and splits it into frames. A header carries a 24-bit length count. A mandatory identification frame follows. It names the target device and selects one of two addressing schemes for the rest of the load. After that come payload frames and, when explicit addressing is chosen, address frames. The block turns them into write requests made of an address and a payload word, for a frame memory sitting next to it.

Every frame carries an 8-bit checksum that is always checked. No write leaves the block until the frame behind it has passed that check. The load ends with a closing frame that has the shape of an address frame, with the top address and an all-ones checksum. At that point the block compares the number of bits consumed with the length count, then pulses done or raises an error. Any error is sticky and stops all further writes until a synchronous reset.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset the outputs are quiet: err_o is zero, wr_o is low and done_o is low.
- R2: While waiting for the header, 1 bits are skipped. The first 0 begins the preamble, which must read 0,0,1,0; any other value sets err_o[0]. The 24-bit length count follows the preamble, MSB first.
- R3: The first frame after the header must be of kind 00 (identification). Its 16-bit payload holds the device ID in bits [15:8] and the addressing mode in bit [0], where 1 means explicit. A missing identification frame, or a device ID that differs from DEV_ID, sets err_o[1].
- R4: A frame is the start pair 0 then 1, a 2-bit kind (00 identification, 01 data, 10 address), the payload MSB first (16 bits, DATA_W bits or ADDR_W bits by kind), an 8-bit checksum, and 4 stop bits of 1. Between frames, 1 bits are ignored. A 0 where the second start bit or a stop bit belongs sets err_o[3].
- R5: The checksum is the modulo-256 sum of the payload bytes. A mismatch sets err_o[2], and that frame is never written.
- R6: In autoincrement mode each data frame is written at addresses 0, 1, 2 and so on, in order of arrival. wr_o is high for the one cycle after the frame's last stop bit, with wr_addr_o and wr_data_o valid.
- R7: In explicit mode a data frame is held, and each address frame after it writes the held data at its own address, so one data frame can be written several times. The following set err_o[4]: an address frame in autoincrement mode, an address frame with no data held, a second identification frame, or kind 11.
- R8: The closing frame is an address frame with an all-ones address and checksum 8'hFF. Let N be the number of valid bits from the first one after reset through the closing frame's last bit. If N equals the length count, done_o pulses for one cycle after that last bit. Otherwise err_o[5] is set.
- R9: Error bits never clear except by reset. Once any bit is set, no further wr_o or done_o is produced.
- R10: Cycles with bit_vld low are ignored, whatever the value of bit_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | bit_in holds a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| wr_o | output | 1 | One-cycle frame write strobe |
| wr_addr_o | output | ADDR_W | Frame write address |
| wr_data_o | output | DATA_W | Frame write data |
| done_o | output | 1 | One-cycle pulse at a clean end of load |
| err_o | output | 6 | Sticky errors: [0] preamble, [1] identification, [2] checksum, [3] start/stop, [4] frame order, [5] length |

## Verification
The bench attacks a checksum fault in the second data frame of an explicit load. A design that checks too late would still write that frame to its pending addresses, and the bench would see writes it did not expect. It sends a load with no identification frame, a mismatched device ID, a bad preamble, a zero stop bit and an address frame in autoincrement mode. A parser that treats any of these as legal would emit writes or a done pulse instead of the right error bit. Length counts one bit off, long runs of leading ones and random idle cycles show whether a design counts idle cycles, or skips header bits, toward the length check. Random loads in both modes compare every write's address and data against a model of the stream that the bench builds itself.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;

  typedef enum logic [3:0] {
    ST_HDR, ST_PRE, ST_LEN, ST_GAP, ST_START, ST_KIND,
    ST_PAY, ST_CHK, ST_STOP, ST_DONE, ST_FAIL
  } cfg_state_e;

  typedef enum logic [1:0] {
    K_ID   = 2'b00,
    K_DATA = 2'b01,
    K_ADDR = 2'b10,
    K_BAD  = 2'b11
  } frame_kind_e;

  // error bit positions on err_o
  localparam int E_PRE  = 0;
  localparam int E_ID   = 1;
  localparam int E_CSUM = 2;
  localparam int E_FRM  = 3;
  localparam int E_SEQ  = 4;
  localparam int E_LEN  = 5;
  localparam int E_NUM  = 6;

  // widest payload the checksum function accepts
  localparam int SUM_MAXW = 256;

  // modulo-256 sum of all bytes; unused upper bytes are zero
  function automatic logic [7:0] byte_sum(input logic [SUM_MAXW-1:0] v);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < SUM_MAXW / 8; i++) s = s + v[i*8 +: 8];
    return s;
  endfunction

endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  // R8: the length reference grows by exactly one per consumed bit
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfg_frame_pkg::*;
#(
  parameter int          DATA_W = 64,
  parameter int          ADDR_W = 16,
  parameter int          LEN_W  = 24,
  parameter logic [7:0]  DEV_ID = 8'hA5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_vld,
  input  logic                bit_in,
  output logic                wr_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                done_o,
  output logic [E_NUM-1:0]    err_o
);
  localparam int ID_W   = 16;
  localparam int MAX1   = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int MAX2   = (MAX1 > ID_W) ? MAX1 : ID_W;
  localparam int SRW    = (MAX2 > LEN_W) ? MAX2 : LEN_W;
  localparam int CW     = $clog2(SRW + 1);
  // start pair + kind + checksum = 12 bits; pad to a byte with stop bits
  localparam int STOP_N = (8 - (12 % 8)) % 8;

  function automatic int pay_len(input frame_kind_e k);
    case (k)
      K_ID:    return ID_W;
      K_DATA:  return DATA_W;
      default: return ADDR_W;
    endcase
  endfunction

  function automatic logic [SRW-1:0] pay_mask(input frame_kind_e k);
    return (SRW'(1) << pay_len(k)) - SRW'(1);
  endfunction

  cfg_state_e           st, st_n;
  logic [CW-1:0]        cnt, cnt_n;
  frame_kind_e          kind_q;
  logic [SRW-1:0]       pay_q, sh_q, sh_nxt;
  logic                 post_q, csum_ok_q, mode_q, id_seen_q, held_v_q;
  logic [DATA_W-1:0]    held_q;
  logic [ADDR_W-1:0]    auto_addr_q, wa_n;
  logic [DATA_W-1:0]    wd_n;
  logic [LEN_W-1:0]     len_q, bits_seen;

  // named internal events
  logic                 v, chk_end, frame_end, fire_wr, fire_done, post_hit, csum_match;
  logic [E_NUM-1:0]     err_set;
  logic [7:0]           csum_calc;

  assign v = bit_vld && (st != ST_DONE) && (st != ST_FAIL);

  cfg_bit_counter #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .en(v), .cnt(bits_seen));

  cfg_shifter #(.W(SRW)) u_sh (
    .clk(clk), .rst(rst), .en(v), .din(bit_in), .q(sh_q), .nxt(sh_nxt));

  assign csum_calc  = byte_sum(SUM_MAXW'(pay_q));
  assign csum_match = (sh_nxt[7:0] == csum_calc);
  assign post_hit   = (kind_q == K_ADDR) && (pay_q[ADDR_W-1:0] == '1) &&
                      (sh_nxt[7:0] == 8'hFF);

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    err_set   = '0;
    fire_wr   = 1'b0;
    fire_done = 1'b0;
    chk_end   = 1'b0;
    frame_end = 1'b0;
    wa_n      = auto_addr_q;
    wd_n      = pay_q[DATA_W-1:0];
    if (v) begin
      case (st)
        ST_HDR: if (!bit_in) begin st_n = ST_PRE; cnt_n = CW'(1); end
        ST_PRE: begin
          // preamble 0,0,1,0: only position 2 is a one
          if (bit_in != (cnt == CW'(2))) err_set[E_PRE] = 1'b1;
          else if (cnt == CW'(3)) begin st_n = ST_LEN; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        ST_LEN: begin
          if (cnt == CW'(LEN_W - 1)) begin st_n = ST_GAP; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        ST_GAP: if (!bit_in) st_n = ST_START;
        ST_START: begin
          if (!bit_in) err_set[E_FRM] = 1'b1;
          else begin st_n = ST_KIND; cnt_n = '0; end
        end
        ST_KIND: begin
          if (cnt == '0) cnt_n = CW'(1);
          else if (sh_nxt[1:0] == K_BAD) err_set[E_SEQ] = 1'b1;
          else if (!id_seen_q && sh_nxt[1:0] != K_ID) err_set[E_ID] = 1'b1;
          else if (id_seen_q && sh_nxt[1:0] == K_ID) err_set[E_SEQ] = 1'b1;
          else begin st_n = ST_PAY; cnt_n = '0; end
        end
        ST_PAY: begin
          if (cnt == CW'(pay_len(kind_q) - 1)) begin st_n = ST_CHK; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
        ST_CHK: begin
          if (cnt == CW'(7)) begin
            chk_end = 1'b1;
            if (!post_hit && !csum_match) err_set[E_CSUM] = 1'b1;
            else begin st_n = ST_STOP; cnt_n = '0; end
          end else cnt_n = cnt + 1'b1;
        end
        ST_STOP: begin
          if (!bit_in) err_set[E_FRM] = 1'b1;
          else if (cnt == CW'(STOP_N - 1)) begin
            frame_end = 1'b1;
            st_n      = ST_GAP;
            case (kind_q)
              K_ID: if (pay_q[15:8] != DEV_ID) err_set[E_ID] = 1'b1;
              K_DATA: if (!mode_q) fire_wr = 1'b1;
              default: begin
                if (post_q) begin
                  if (LEN_W'(bits_seen + 1'b1) != len_q) err_set[E_LEN] = 1'b1;
                  else begin fire_done = 1'b1; st_n = ST_DONE; end
                end else if (!mode_q || !held_v_q) err_set[E_SEQ] = 1'b1;
                else begin
                  fire_wr = 1'b1;
                  wa_n    = pay_q[ADDR_W-1:0];
                  wd_n    = held_q;
                end
              end
            endcase
          end else cnt_n = cnt + 1'b1;
        end
        default: ;
      endcase
    end
    if (err_set != '0) st_n = ST_FAIL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HDR;  cnt <= '0;  kind_q <= K_ID;  pay_q <= '0;
      post_q <= 1'b0;  csum_ok_q <= 1'b0;  mode_q <= 1'b0;  id_seen_q <= 1'b0;
      held_q <= '0;  held_v_q <= 1'b0;  auto_addr_q <= '0;  len_q <= '0;
      wr_o <= 1'b0;  wr_addr_o <= '0;  wr_data_o <= '0;  done_o <= 1'b0;  err_o <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      err_o  <= err_o | err_set;
      wr_o   <= fire_wr;
      done_o <= fire_done;
      if (fire_wr) begin
        wr_addr_o <= wa_n;
        wr_data_o <= wd_n;
        if (!mode_q) auto_addr_q <= auto_addr_q + 1'b1;
      end
      if (v && st == ST_LEN && cnt == CW'(LEN_W - 1)) len_q <= sh_nxt[LEN_W-1:0];
      if (v && st == ST_START) begin post_q <= 1'b0; csum_ok_q <= 1'b0; end
      if (v && st == ST_KIND && cnt != '0) kind_q <= frame_kind_e'(sh_nxt[1:0]);
      if (v && st == ST_PAY && cnt == CW'(pay_len(kind_q) - 1))
        pay_q <= sh_nxt & pay_mask(kind_q);
      if (chk_end) begin
        post_q    <= post_hit;
        csum_ok_q <= post_hit || csum_match;
      end
      if (frame_end && kind_q == K_ID) begin
        mode_q    <= pay_q[0];
        id_seen_q <= 1'b1;
      end
      if (frame_end && kind_q == K_DATA && mode_q) begin
        held_q   <= pay_q[DATA_W-1:0];
        held_v_q <= 1'b1;
      end
    end
  end

  // R5: a write is issued only for a frame whose checksum passed
  a_r5_wr_needs_csum: assert property (@(posedge clk) disable iff (rst)
    fire_wr |-> csum_ok_q);

  // R9: error bits never clear
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_o != '0) |=> ((err_o & $past(err_o)) == $past(err_o)));

  // R9: no write or done once an error is flagged
  a_r9_quiet_after_err: assert property (@(posedge clk) disable iff (rst)
    (err_o != '0) |-> (!wr_o && !done_o));

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: writes and done never coincide
  a_r6_wr_not_done: assert property (@(posedge clk) disable iff (rst)
    !(wr_o && done_o));

endmodule

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;
  localparam int         DATA_W = 64;
  localparam int         ADDR_W = 16;
  localparam logic [7:0] DEV_ID = 8'hA5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bit_vld = 1'b0;
  logic              bit_in = 1'b0;
  logic              wr_o, done_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [DATA_W-1:0] wr_data_o;
  logic [5:0]        err_o;

  cfg_stream_parser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(24), .DEV_ID(DEV_ID)) dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .wr_o(wr_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o), .err_o(err_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit body[$];
  logic [ADDR_W-1:0] exp_a[64];
  logic [DATA_W-1:0] exp_d[64];
  logic [ADDR_W-1:0] got_a[64];
  logic [DATA_W-1:0] got_d[64];
  int exp_n, got_n, done_n;
  logic [DATA_W-1:0] held;

  always @(negedge clk) begin
    if (!rst && wr_o) begin
      if (got_n < 64) begin got_a[got_n] = wr_addr_o; got_d[got_n] = wr_data_o; end
      got_n++;
    end
    if (!rst && done_o) done_n++;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_sum(input logic [63:0] p, input int nbits);
    logic [7:0] s = 0;
    logic [63:0] t = p;
    for (int b = 0; b < nbits / 8; b++) begin
      s = s + t[7:0];
      t = t >> 8;
    end
    return s;
  endfunction

  task automatic put(input logic [63:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) body.push_back(val[i]);
  endtask

  task automatic frame(input logic [1:0] kind, input logic [63:0] pay, input int plen,
                       input logic [7:0] chk_xor, input bit bad_stop);
    put(64'hF, $urandom_range(0, 3));
    put(64'b01, 2);
    put(64'(kind), 2);
    put(pay, plen);
    put(64'(tb_sum(pay, plen) ^ chk_xor), 8);
    put(bad_stop ? 64'b1101 : 64'b1111, 4);
  endtask

  task automatic id_frame(input logic [7:0] id, input bit expl);
    frame(2'b00, {48'd0, id, 7'd0, expl}, 16, 8'h00, 1'b0);
  endtask

  task automatic data_frame(input logic [63:0] d, input bit expl);
    frame(2'b01, d, DATA_W, 8'h00, 1'b0);
    if (expl) held = d;
    else begin exp_a[exp_n] = ADDR_W'(exp_n); exp_d[exp_n] = d; exp_n++; end
  endtask

  task automatic addr_frame(input logic [ADDR_W-1:0] a);
    frame(2'b10, 64'(a), ADDR_W, 8'h00, 1'b0);
    exp_a[exp_n] = a; exp_d[exp_n] = held; exp_n++;
  endtask

  task automatic post_frame();
    put(64'b01, 2); put(64'b10, 2); put(64'hFFFF, ADDR_W); put(64'hFF, 8); put(64'hF, 4);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_vld = 1'b0;
    body.delete(); exp_n = 0; held = '0;
    repeat (3) @(negedge clk);
    got_n = 0; done_n = 0;
    rst = 1'b0;
  endtask

  task automatic drive(input bit b);
    while ($urandom_range(0, 7) == 0) begin   // R10: idle cycles with junk data
      bit_vld = 1'b0; bit_in = 1'($urandom); @(negedge clk);
    end
    bit_vld = 1'b1; bit_in = b; @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic run_load(input int nones, input int len_adj, input bit bad_pre);
    int total = nones + 28 + body.size();
    logic [23:0] len = 24'(total + len_adj);
    for (int i = 0; i < nones; i++) drive(1'b1);
    drive(1'b0); drive(1'b0); drive(1'b1); drive(bad_pre);
    for (int i = 23; i >= 0; i--) drive(len[i]);
    foreach (body[i]) drive(body[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic verify(input string tag, input logic [5:0] e_err, input int e_done);
    check(got_n == exp_n, {tag, " write count"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_a[i] == exp_a[i], {tag, " write addr"}, 64'(got_a[i]), 64'(exp_a[i]));
      check(got_d[i] == exp_d[i], {tag, " write data"}, got_d[i], exp_d[i]);
    end
    check(err_o == e_err, {tag, " err"}, 64'(err_o), 64'(e_err));
    check(done_n == e_done, {tag, " done"}, 64'(done_n), 64'(e_done));
  endtask

  initial begin
    void'($urandom(32'd7));
    do_reset();
    @(negedge clk);
    check(err_o == 0 && !wr_o && !done_o, "R1 reset outputs", {err_o, wr_o, done_o}, 0);

    // R6: autoincrement load
    do_reset();
    id_frame(DEV_ID, 0);
    for (int i = 0; i < 3; i++) data_frame({$urandom, $urandom}, 0);
    post_frame(); run_load(3, 0, 0);
    verify("R6 auto", 6'd0, 1);

    // R7: explicit with multi-address write
    do_reset();
    id_frame(DEV_ID, 1);
    data_frame(64'h0123_4567_89AB_CDEF, 1); addr_frame(16'h0040); addr_frame(16'h0007);
    data_frame(64'hFEDC_BA98_7654_3210, 1); addr_frame(16'h1234);
    post_frame(); run_load(2, 0, 0);
    verify("R7 explicit", 6'd0, 1);

    // R5/R9: corrupt checksum on second data frame; later frames ignored
    do_reset();
    id_frame(DEV_ID, 1);
    data_frame(64'h1111_2222_3333_4444, 1); addr_frame(16'h0010); addr_frame(16'h0011);
    frame(2'b01, 64'h5555, DATA_W, 8'h01, 1'b0);
    frame(2'b10, 64'h0020, ADDR_W, 8'h00, 1'b0);
    post_frame(); run_load(1, 0, 0);
    verify("R5 R9 bad checksum", 6'b000100, 0);

    // R3: device ID mismatch
    do_reset();
    id_frame(8'h5A, 0); data_frame(64'h9, 0); exp_n = 0;
    post_frame(); run_load(1, 0, 0);
    verify("R3 id mismatch", 6'b000010, 0);

    // R3: identification frame missing
    do_reset();
    data_frame(64'h9, 0); exp_n = 0;
    post_frame(); run_load(1, 0, 0);
    verify("R3 id missing", 6'b000010, 0);

    // R2: bad preamble
    do_reset();
    id_frame(DEV_ID, 0); data_frame(64'h9, 0); exp_n = 0;
    post_frame(); run_load(1, 0, 1);
    verify("R2 bad preamble", 6'b000001, 0);

    // R8: length count one too large
    do_reset();
    id_frame(DEV_ID, 0); data_frame(64'hABCD, 0); data_frame(64'h1, 0);
    post_frame(); run_load(2, 1, 0);
    verify("R8 length mismatch", 6'b100000, 0);

    // R4: zero stop bit
    do_reset();
    id_frame(DEV_ID, 0); frame(2'b01, 64'h77, DATA_W, 8'h00, 1'b1);
    post_frame(); run_load(1, 0, 0);
    verify("R4 stop bit", 6'b001000, 0);

    // R7: address frame in autoincrement mode
    do_reset();
    id_frame(DEV_ID, 0); data_frame(64'h42, 0);
    frame(2'b10, 64'h3, ADDR_W, 8'h00, 1'b0);
    post_frame(); run_load(1, 0, 0);
    verify("R7 addr in auto", 6'b010000, 0);

    // R2: long run of leading ones
    do_reset();
    id_frame(DEV_ID, 0); data_frame(64'hDEAD_BEEF, 0);
    post_frame(); run_load(40, 0, 0);
    verify("R2 long header ones", 6'd0, 1);

    // R6 R7 R8 R10: random loads
    for (int k = 0; k < 12; k++) begin
      bit expl = 1'($urandom);
      do_reset();
      id_frame(DEV_ID, expl);
      for (int f = 0; f < int'($urandom_range(1, 4)); f++) begin
        data_frame({$urandom, $urandom}, expl);
        if (expl)
          for (int a = 0; a < int'($urandom_range(1, 3)); a++)
            addr_frame(ADDR_W'($urandom) & 16'hFFFE);
      end
      post_frame(); run_load($urandom_range(1, 8), 0, 0);
      verify("R6 R7 R8 R10 random", 6'd0, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule